// File: doc/BRIEF.md
# Arithmetic Logic Unit with Negative/Zero Flags

This block is the arithmetic and logic stage of a microcoded 32-bit core. Each cycle it takes two operands and a four-bit operation code. From these it forms a result combinationally. The operations are add, subtract, multiply, signed divide, the three bitwise logic operations, logical shifts in both directions, and an upper-immediate load.

Beside the result the block holds a two-bit flag register: N (negative) and Z (zero). The flags load from the current result at the clock edge only when the microinstruction raises the flag-write input. Otherwise they keep their value. The sequencer picks one of four branch conditions. The block reports whether that condition holds for the stored flags. The intended use is to set the flags with a subtract of the two compared registers, then test the condition in a later microstep.

Top module: `nzalu_top`

## Requirements
- R1: Operation code 0 returns a + b and code 1 returns a − b, both modulo 2^32.
- R2: Code 2 returns a AND b, code 3 returns a OR b, and code 4 returns a XOR b.
- R3: Code 5 returns the low 32 bits of the product a × b.
- R4: Code 6 returns the signed quotient a / b, truncated toward zero. When b is zero the result is all ones. The case 0x80000000 / −1 returns 0x80000000.
- R5: Code 7 shifts a left and code 8 shifts a right logically. Both take the shift amount from b[4:0] only, and both fill vacated bits with zeros.
- R6: Code 9 returns b shifted left by 12, with the low 12 bits zero.
- R7: Operation codes 10 to 15 return a result of zero.
- R8: When flag_we is high at a rising clock edge, N takes result bit 31 and Z takes (result == 0). Both are visible after that edge.
- R9: When flag_we is low at a rising clock edge, N and Z keep their values whatever the operands and operation.
- R10: cond_met reflects the stored flags through cond_sel: 0 gives Z (equal), 1 gives not Z (not equal), 2 gives not Z and not N (greater than), and 3 gives Z or N (less or equal).
- R11: An active-low reset clears N and Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand, shift amount or upper immediate |
| op_i | input | 4 | Operation code (see R1 to R7) |
| flag_we_i | input | 1 | Load N and Z from the result at this edge |
| cond_sel_i | input | 2 | Branch condition select (see R10) |
| result_o | output | 32 | Combinational result |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| cond_met_o | output | 1 | Selected condition holds for the stored flags |

## Verification
The assertions assume that every input is driven to a known value at each rising edge after reset, and that rst_ni is low at the first edge. The flag properties compare against the result that was present at the previous edge. This only holds if the operands stay stable around that edge. The bench therefore changes every input on the falling edge and drives a defined value on each of them throughout.

// File: rtl/nzalu_pkg.sv
package nzalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_MUL = 4'd5,
        OP_DIV = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_LUI = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        CND_EQ = 2'd0,
        CND_NE = 2'd1,
        CND_GT = 2'd2,
        CND_LE = 2'd3
    } cond_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } flags_t;

endpackage

// File: rtl/nzalu_datapath.sv
module nzalu_datapath
    import nzalu_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int LUI_SHIFT = 12
) (
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int SHAMT_W = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic [SHAMT_W-1:0] shamt;
    logic [WIDTH-1:0]   quot;
    logic               div_zero;
    logic               div_ovf;

    assign shamt    = op_b_i[SHAMT_W-1:0];
    assign div_zero = (op_b_i == '0);
    assign div_ovf  = (op_a_i == MIN_NEG) && (op_b_i == '1);

    always_comb begin
        if (div_zero) begin
            quot = '1;
        end else if (div_ovf) begin
            quot = MIN_NEG;
        end else begin
            quot = WIDTH'($signed(op_a_i) / $signed(op_b_i));
        end
    end

    always_comb begin
        case (alu_op_e'(op_i))
            OP_ADD:  result_o = op_a_i + op_b_i;
            OP_SUB:  result_o = op_a_i - op_b_i;
            OP_AND:  result_o = op_a_i & op_b_i;
            OP_OR:   result_o = op_a_i | op_b_i;
            OP_XOR:  result_o = op_a_i ^ op_b_i;
            OP_MUL:  result_o = op_a_i * op_b_i;
            OP_DIV:  result_o = quot;
            OP_SHL:  result_o = op_a_i << shamt;
            OP_SHR:  result_o = op_a_i >> shamt;
            OP_LUI:  result_o = op_b_i << LUI_SHIFT;
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/nzalu_flags.sv
module nzalu_flags
    import nzalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [WIDTH-1:0] result_i,
    output flags_t           flags_o
);
    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we_i) begin
            flags_d.neg  = result_i[WIDTH-1];
            flags_d.zero = (result_i == '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/nzalu_cond.sv
module nzalu_cond
    import nzalu_pkg::*;
(
    input  flags_t     flags_i,
    input  logic [1:0] sel_i,
    output logic       met_o
);
    always_comb begin
        case (cond_e'(sel_i))
            CND_EQ:  met_o = flags_i.zero;
            CND_NE:  met_o = !flags_i.zero;
            CND_GT:  met_o = !flags_i.zero && !flags_i.neg;
            default: met_o = flags_i.zero || flags_i.neg;
        endcase
    end

endmodule

// File: rtl/nzalu_top.sv
module nzalu_top
    import nzalu_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int LUI_SHIFT = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic [3:0]       op_i,
    input  logic             flag_we_i,
    input  logic [1:0]       cond_sel_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             cond_met_o
);
    flags_t flags;

    nzalu_datapath #(
        .WIDTH     (WIDTH),
        .LUI_SHIFT (LUI_SHIFT)
    ) u_datapath (
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .op_i     (op_i),
        .result_o (result_o)
    );

    nzalu_flags #(
        .WIDTH (WIDTH)
    ) u_flags (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (flag_we_i),
        .result_i (result_o),
        .flags_o  (flags)
    );

    nzalu_cond u_cond (
        .flags_i (flags),
        .sel_i   (cond_sel_i),
        .met_o   (cond_met_o)
    );

    assign flag_n_o = flags.neg;
    assign flag_z_o = flags.zero;

endmodule

// File: rtl/nzalu_chk.sv
module nzalu_chk #(
    parameter int WIDTH     = 32,
    parameter int LUI_SHIFT = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIDTH-1:0] op_a_i,
    input logic [WIDTH-1:0] op_b_i,
    input logic [3:0]       op_i,
    input logic             flag_we_i,
    input logic [1:0]       cond_sel_i,
    input logic [WIDTH-1:0] result_o,
    input logic             flag_n_o,
    input logic             flag_z_o,
    input logic             cond_met_o
);
    p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_we_i |=> $stable({flag_n_o, flag_z_o}));

    p_zflag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_i |=> flag_z_o == ($past(result_o) == '0));

    p_nflag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_i |=> flag_n_o == $past(result_o[WIDTH-1]));

    p_divzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd6 && op_b_i == '0) |-> result_o == '1);

    p_lui_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd9) |-> result_o[LUI_SHIFT-1:0] == '0);

    p_gt_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_sel_i == 2'd2) |-> cond_met_o == (!flag_n_o && !flag_z_o));

    p_le_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_sel_i == 2'd3) |-> cond_met_o == (flag_n_o || flag_z_o));

    p_reset_clear_r11: assert property (@(posedge clk_i)
        !rst_ni |=> (!flag_n_o && !flag_z_o));

endmodule

bind nzalu_top nzalu_chk #(.WIDTH(WIDTH), .LUI_SHIFT(LUI_SHIFT)) u_chk (.*);

// File: tb/nzalu_top_tb.sv
module nzalu_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [3:0]  op_i = '0;
    logic        flag_we_i = 1'b0;
    logic [1:0]  cond_sel_i = '0;
    logic [31:0] result_o;
    logic        flag_n_o;
    logic        flag_z_o;
    logic        cond_met_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // {op, a, b, expected result}
    localparam logic [99:0] VEC [NVEC] = '{
        {4'd0, 32'd5,          32'd7,          32'd12},         // R1
        {4'd0, 32'hFFFFFFFF,   32'd1,          32'h00000000},   // R1 wrap
        {4'd1, 32'd3,          32'd5,          32'hFFFFFFFE},   // R1
        {4'd2, 32'hF0F0F0F0,   32'hFF00FF00,   32'hF000F000},   // R2
        {4'd3, 32'h00000F00,   32'h000000F0,   32'h00000FF0},   // R2
        {4'd4, 32'hAAAA5555,   32'hFFFF0000,   32'h55555555},   // R2
        {4'd5, 32'h00010000,   32'h00010000,   32'h00000000},   // R3
        {4'd5, 32'hFFFFFFFF,   32'd3,          32'hFFFFFFFD},   // R3
        {4'd6, 32'd100,        32'd7,          32'd14},         // R4
        {4'd6, 32'hFFFFFF9C,   32'd7,          32'hFFFFFFF2},   // R4 -100/7
        {4'd6, 32'd5,          32'd0,          32'hFFFFFFFF},   // R4 /0
        {4'd6, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},   // R4 ovf
        {4'd7, 32'd1,          32'h00000021,   32'd2},          // R5
        {4'd8, 32'h80000000,   32'd4,          32'h08000000},   // R5
        {4'd8, 32'h80000000,   32'h00000024,   32'h08000000},   // R5
        {4'd7, 32'hFFFFFFFF,   32'd31,         32'h80000000},   // R5
        {4'd9, 32'hDEADBEEF,   32'h00012345,   32'h12345000},   // R6
        {4'd9, 32'd0,          32'h000FFFFF,   32'hFFFFF000},   // R6
        {4'd10, 32'd9,         32'd9,          32'd0},          // R7
        {4'd15, 32'hFFFFFFFF,  32'hFFFFFFFF,   32'd0},          // R7
        {4'd1, 32'd9,          32'd9,          32'd0},          // R1 equal
        {4'd0, 32'h7FFFFFFF,   32'd1,          32'h80000000}    // R1
    };

    nzalu_top u_dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .op_i       (op_i),
        .flag_we_i  (flag_we_i),
        .cond_sel_i (cond_sel_i),
        .result_o   (result_o),
        .flag_n_o   (flag_n_o),
        .flag_z_o   (flag_z_o),
        .cond_met_o (cond_met_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Sets flags with a subtract a-b, then tests all four conditions.
    task automatic cond_case(input logic [31:0] a, input logic [31:0] b, input logic [3:0] exp_met);
        @(negedge clk_i);
        op_i = 4'd1; op_a_i = a; op_b_i = b; flag_we_i = 1'b1;
        @(negedge clk_i);
        flag_we_i = 1'b0;
        for (int s = 0; s < 4; s++) begin
            cond_sel_i = 2'(s);
            #1;
            check("R10 cond", {31'd0, cond_met_o}, {31'd0, exp_met[s]});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R11: reset clears the flags
        repeat (2) @(negedge clk_i);
        check("R11 reset", {30'd0, flag_n_o, flag_z_o}, 32'd0);
        rst_ni = 1'b1;

        // Vector table: result and flags for each operation (R1-R8 per entry)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk_i);
            op_i = VEC[i][99:96];
            op_a_i = VEC[i][95:64];
            op_b_i = VEC[i][63:32];
            flag_we_i = 1'b1;
            #1;
            check("R1..R7 result", result_o, VEC[i][31:0]);
            @(negedge clk_i);
            check("R8 flags", {30'd0, flag_n_o, flag_z_o},
                  {30'd0, VEC[i][31], VEC[i][31:0] == 32'd0});
        end

        // R9: flags hold while flag_we is low
        @(negedge clk_i);
        op_i = 4'd1; op_a_i = 32'd2; op_b_i = 32'd5; flag_we_i = 1'b1;  // negative
        @(negedge clk_i);
        op_i = 4'd0; op_a_i = 32'd0; op_b_i = 32'd0; flag_we_i = 1'b0;  // zero result
        @(negedge clk_i);
        @(negedge clk_i);
        check("R9 hold", {30'd0, flag_n_o, flag_z_o}, 32'd2);

        // R10: conditions {LE,GT,NE,EQ} bits 3..0
        cond_case(32'd5, 32'd3, 4'b0110);          // greater
        cond_case(32'd3, 32'd3, 4'b1001);          // equal
        cond_case(32'd3, 32'd5, 4'b1010);          // less

        // R11: reset mid-run clears flags set to negative
        @(negedge clk_i);
        op_i = 4'd1; op_a_i = 32'd0; op_b_i = 32'd1; flag_we_i = 1'b1;
        @(negedge clk_i);
        flag_we_i = 1'b0;
        rst_ni = 1'b0;
        #1;
        check("R11 async reset", {30'd0, flag_n_o, flag_z_o}, 32'd0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        done = 1'b1;
        finish_run();
    end

endmodule